// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two USB data lines for a single-ended-zero (SE0) state, where D+ and D- are both low, and decides whether that state lasted long enough to count as a bus reset. The lines arrive asynchronously and pass through a synchronizer. A counter then measures how many consecutive clock samples showed SE0. When the count reaches a qualification threshold, the block raises a sticky status flag, holds the processor in reset, and, if the device was suspended, sends a one-cycle request to leave suspend and restart the oscillator.

The processor hold stays on for as long as the bus keeps SE0. It is released as soon as the synchronized lines leave SE0, and execution then restarts from the reset vector. Firmware clears the status flag by writing 0 to it.

The threshold is a parameter counted in clock cycles. It must lie between the 8 µs and 16 µs equivalents at the chosen clock, which are `8*CLK_MHZ` and `16*CLK_MHZ` cycles. The default is `12*CLK_MHZ`.

Top module: `usb_bus_reset_det`

## Requirements
- R1: SE0 is counted only while both synchronized lines are low; a low on only one line (D+ low with D- high, or D- low with D+ high) never advances the count or raises the flag.
- R2: A run of fewer than QUAL_CYCLES consecutive synchronized SE0 samples leaves `busResetFlag`, `cpuHold` and `oscWake` at 0. With the defaults this includes any SE0 shorter than 8 µs.
- R3: The QUAL_CYCLES-th consecutive SE0 sample sets `busResetFlag` and `cpuHold` to 1 at the next clock edge. The line-to-flag latency is QUAL_CYCLES plus SYNC_STAGES edges, so any SE0 longer than 16 µs is always recognized.
- R4: `busResetFlag` is sticky. A cycle with `flagWrEn`=1 and `flagWrData`=0 clears it. A write with `flagWrData`=1 has no effect. If a new reset is recognized in the same cycle as a clear, the set wins.
- R5: `cpuHold` stays at 1 while synchronized SE0 persists. It returns to 0 on the first clock edge that sees a non-SE0 synchronized sample.
- R6: `oscWake` pulses high for exactly one cycle, one edge after recognition, and only if `suspendIn` was 1 in the recognition cycle. It does not pulse again during the same SE0.
- R7: Any single non-SE0 synchronized sample restarts the duration count from zero, so two SE0 runs shorter than QUAL_CYCLES separated by a one-cycle glitch are not recognized.
- R8: While `rstN` is low, all outputs are 0, and the synchronizer presets to the non-SE0 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dpLine | input | 1 | D+ line level, asynchronous |
| dmLine | input | 1 | D- line level, asynchronous |
| suspendIn | input | 1 | 1 while the device is in suspend |
| flagWrEn | input | 1 | Firmware write strobe for the status flag |
| flagWrData | input | 1 | Value written to the status flag (only 0 acts) |
| busResetFlag | output | 1 | Sticky bus-reset recorded flag |
| oscWake | output | 1 | One-cycle request to exit suspend and restart the oscillator |
| cpuHold | output | 1 | Holds the processor in reset while bus reset persists |

## Verification
The bench keeps the default parameters: a 50 MHz clock, two synchronizer stages and a 600-cycle threshold. These defaults place the 8 µs point at 400 cycles and the 16 µs point at 800 cycles. That brings runs of 390, 599, 600 and 900 cycles into reach within a few thousand clocks, so both sides of the threshold are exercised, along with a run past 16 µs. The same build covers a clear write held across the recognition cycle and glitch-split runs, while a behavioural model compares all three outputs on every clock.

// File: rtl/usbrst_pkg.sv
package usbrst_pkg;
  // control -> datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } cntStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic se0Now;   // synchronized lines both low
    logic cntLast;  // count one short of threshold
    logic cntFull;  // count saturated at threshold
  } lineStatus_t;
endpackage

// File: rtl/usbrst_datapath.sv
module usbrst_datapath
  import usbrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dpLine,
  input  logic        dmLine,
  input  cntStrobe_t  strobe,
  output lineStatus_t status
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam int SMSB  = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] dpSync;
  logic [SYNC_STAGES-1:0] dmSync;
  logic [CNT_W-1:0]       se0Cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dpSync <= 1'b1;
          dmSync <= 1'b1;
        end else begin
          dpSync <= dpLine;
          dmSync <= dmLine;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dpSync <= '1;
          dmSync <= '1;
        end else begin
          dpSync <= {dpSync[SYNC_STAGES-2:0], dpLine};
          dmSync <= {dmSync[SYNC_STAGES-2:0], dmLine};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               se0Cnt <= '0;
    else if (strobe.cntClear) se0Cnt <= '0;
    else if (strobe.cntStep)  se0Cnt <= se0Cnt + 1'b1;
  end

  always_comb begin
    status.se0Now  = !dpSync[SMSB] && !dmSync[SMSB];
    status.cntLast = (se0Cnt == CNT_W'(QUAL_CYCLES - 1));
    status.cntFull = (se0Cnt == CNT_W'(QUAL_CYCLES));
  end

  // a clear strobe from control must empty the count (glitch restart)
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (se0Cnt == '0));

  // count never runs past the threshold
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    se0Cnt <= CNT_W'(QUAL_CYCLES));
endmodule

// File: rtl/usbrst_control.sv
module usbrst_control
  import usbrst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lineStatus_t status,
  input  logic        suspendIn,
  input  logic        flagWrEn,
  input  logic        flagWrData,
  output cntStrobe_t  strobe,
  output logic        busResetFlag,
  output logic        oscWake,
  output logic        cpuHold
);
  logic hit;

  always_comb begin
    strobe.cntClear = !status.se0Now;
    strobe.cntStep  = status.se0Now && !status.cntFull;
    hit             = status.se0Now && status.cntLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busResetFlag <= 1'b0;
      cpuHold      <= 1'b0;
      oscWake      <= 1'b0;
    end else begin
      if (hit)                          busResetFlag <= 1'b1;
      else if (flagWrEn && !flagWrData) busResetFlag <= 1'b0;
      cpuHold <= hit || (cpuHold && status.se0Now);
      oscWake <= hit && suspendIn;
    end
  end

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busResetFlag && !(flagWrEn && !flagWrData)) |=> busResetFlag);

  assert_hold_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHold && !status.se0Now) |=> !cpuHold);

  assert_hold_with_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHold) |-> busResetFlag);

  assert_wake_suspended_R6: assert property (@(posedge clk) disable iff (!rstN)
    oscWake |-> $past(suspendIn));

  assert_wake_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    oscWake |=> !oscWake);
endmodule

// File: rtl/usb_bus_reset_det.sv
module usb_bus_reset_det
  import usbrst_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 12 * CLK_MHZ
) (
  input  logic clk,
  input  logic rstN,
  input  logic dpLine,
  input  logic dmLine,
  input  logic suspendIn,
  input  logic flagWrEn,
  input  logic flagWrData,
  output logic busResetFlag,
  output logic oscWake,
  output logic cpuHold
);
  cntStrobe_t  strobe;
  lineStatus_t status;

  usbrst_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .dpLine(dpLine),
    .dmLine(dmLine),
    .strobe(strobe),
    .status(status)
  );

  usbrst_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .status      (status),
    .suspendIn   (suspendIn),
    .flagWrEn    (flagWrEn),
    .flagWrData  (flagWrData),
    .strobe      (strobe),
    .busResetFlag(busResetFlag),
    .oscWake     (oscWake),
    .cpuHold     (cpuHold)
  );

  // no output may be active before a full threshold run has been possible
  assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busResetFlag && !cpuHold && !oscWake));
endmodule

// File: tb/usb_bus_reset_det_tb.sv
module usb_bus_reset_det_tb;
  localparam int QUAL = 600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dpLine = 1'b1, dmLine = 1'b0;
  logic suspendIn = 1'b0, flagWrEn = 1'b0, flagWrData = 1'b1;
  logic busResetFlag, oscWake, cpuHold;

  int checks = 0, errors = 0, cycles = 0;
  int wakeCount = 0, flagHighCount = 0;
  string curReq = "R8";

  // behavioural reference
  bit mDp1, mDp2, mDm1, mDm2;
  int mRun;
  bit mFlag, mHold, mWake;

  always #10 clk = ~clk;

  usb_bus_reset_det u_dut (
    .clk(clk), .rstN(rstN), .dpLine(dpLine), .dmLine(dmLine),
    .suspendIn(suspendIn), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .busResetFlag(busResetFlag), .oscWake(oscWake), .cpuHold(cpuHold)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDp1 = 1; mDp2 = 1; mDm1 = 1; mDm2 = 1;
      mRun = 0; mFlag = 0; mHold = 0; mWake = 0;
    end else begin
      bit se0, hit;
      se0 = (mDp2 == 0) && (mDm2 == 0);
      hit = se0 && (mRun == QUAL - 1);
      mWake = hit && suspendIn;
      if (hit) mFlag = 1;
      else if (flagWrEn && !flagWrData) mFlag = 0;
      mHold = hit || (mHold && se0);
      if (!se0) mRun = 0;
      else if (mRun < QUAL) mRun = mRun + 1;
      mDp2 = mDp1; mDp1 = dpLine;
      mDm2 = mDm1; mDm1 = dmLine;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(busResetFlag == mFlag, curReq, "busResetFlag", busResetFlag, mFlag);
      check(cpuHold == mHold, curReq, "cpuHold", cpuHold, mHold);
      check(oscWake == mWake, curReq, "oscWake", oscWake, mWake);
      if (oscWake) wakeCount++;
      if (busResetFlag) flagHighCount++;
    end
  end

  task automatic lines(input bit dp, input bit dm, input int n);
    dpLine = dp; dmLine = dm;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    lines(1'b1, 1'b0, n);
  endtask

  task automatic fwWrite(input bit v);
    flagWrEn = 1'b1; flagWrData = v;
    @(negedge clk);
    flagWrEn = 1'b0; flagWrData = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    check(!busResetFlag && !cpuHold && !oscWake, "R8", "outputs in reset",
          {busResetFlag, cpuHold, oscWake}, 0);
    rstN = 1'b1;
    idle(5);

    curReq = "R1";
    lines(1'b0, 1'b1, 1000);
    lines(1'b1, 1'b0, 1000);
    lines(1'b1, 1'b1, 1000);
    idle(5);
    check(busResetFlag == 0, "R1", "single line low flag", busResetFlag, 0);

    curReq = "R2";
    lines(1'b0, 1'b0, 390); idle(5);
    lines(1'b0, 1'b0, QUAL - 1); idle(5);
    check(busResetFlag == 0 && cpuHold == 0, "R2", "short SE0 flag", busResetFlag, 0);

    curReq = "R3";
    lines(1'b0, 1'b0, QUAL); idle(5);
    check(busResetFlag == 1, "R3", "exact threshold flag", busResetFlag, 1);

    curReq = "R4";
    fwWrite(1'b1); idle(2);
    check(busResetFlag == 1, "R4", "write 1 keeps flag", busResetFlag, 1);
    fwWrite(1'b0); idle(2);
    check(busResetFlag == 0, "R4", "write 0 clears flag", busResetFlag, 0);

    curReq = "R5";
    lines(1'b0, 1'b0, 700);
    check(cpuHold == 1, "R5", "hold during SE0", cpuHold, 1);
    lines(1'b0, 1'b0, 200);
    check(busResetFlag == 1, "R3", "SE0 beyond 16us flag", busResetFlag, 1);
    idle(5);
    check(cpuHold == 0, "R5", "hold after SE0", cpuHold, 0);
    fwWrite(1'b0); idle(2);

    curReq = "R4";
    flagHighCount = 0;
    flagWrEn = 1'b1; flagWrData = 1'b0;
    lines(1'b0, 1'b0, 800); idle(5);
    flagWrEn = 1'b0; flagWrData = 1'b1;
    idle(2);
    check(flagHighCount == 1, "R4", "set over clear cycles", flagHighCount, 1);

    curReq = "R7";
    lines(1'b0, 1'b0, 500);
    lines(1'b1, 1'b0, 1);
    lines(1'b0, 1'b0, 500);
    idle(5);
    check(busResetFlag == 0 && cpuHold == 0, "R7", "glitch restart flag", busResetFlag, 0);

    curReq = "R6";
    wakeCount = 0;
    suspendIn = 1'b0;
    lines(1'b0, 1'b0, 700); idle(5);
    check(wakeCount == 0, "R6", "wake when awake", wakeCount, 0);
    fwWrite(1'b0);
    suspendIn = 1'b1;
    lines(1'b0, 1'b0, 1200); idle(5);
    suspendIn = 1'b0;
    check(wakeCount == 1, "R6", "wake pulses suspended", wakeCount, 1);

    idle(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule